// File: doc/BRIEF.md
# Branch and Jump Next-PC Resolver

This block decides, once per control-flow instruction, whether instruction fetch must leave its sequential path. Two producers send it data through their own four-phase request/acknowledge latches. The decode side sends the instruction's address, its target, whether it is a branch or a jump, and the branch sense. The execute side sends only the zero flag. Either producer may arrive first. When both halves are held, the block raises a request to fetch that carries a redirect flag and an address. It holds that request until fetch acknowledges it. Only then does it free both input latches for the next instruction.

The block also holds the fetch program counter. A redirect that fetch accepts loads the target address into it. Otherwise a fetch step adds 4. The reset is active low.

Top module: `next_pc_resolver`

## Requirements
- R1: While `rst_n` is low and after it rises, `dec_ack`, `exe_ack` and `redir_req` are 0 and `fetch_pc` equals the `RESET_PC` parameter (default 0).
- R2: When `dec_req` is high and no decode data is held, the block captures the decode fields and sets `dec_ack` to 1 one cycle later. `dec_ack` returns to 0 one cycle after `dec_req` is seen low.
- R3: While a decode half is held and its redirect has not yet been acknowledged by fetch, a new `dec_req` is not acknowledged. The block captures it only after that redirect has been accepted, and the next redirect uses the new fields.
- R4: The execute latch captures `exe_zero` under the same four-phase rule as R2, using `exe_req`/`exe_ack`: ack 1 one cycle after a request is taken, and 0 one cycle after the request is seen low.
- R5: `redir_req` stays 0 while only one of the two halves is held. This holds whichever half arrives first.
- R6: If the held decode half has `dec_is_jump`=1, the block sends `redir_valid`=1 and `redir_addr`=`dec_target`.
- R7: If the decode half is a branch (`dec_is_branch`=1, `dec_is_jump`=0), `redir_valid` is 1 exactly when the held zero flag equals `dec_on_zero`. `dec_on_zero`=1 means redirect on zero, and 0 means redirect on non-zero. The address is `dec_target` when `redir_valid` is 1.
- R8: Whenever `redir_valid` is 0, `redir_addr` is `dec_pc`+4.
- R9: Once raised, `redir_req`, `redir_valid` and `redir_addr` stay stable until `redir_ack` is high at a clock edge. `redir_req` is 0 in the next cycle. A new `redir_req` never rises while `redir_ack` is still high.
- R10: When fetch accepts a redirect with `redir_valid`=1, `fetch_pc` becomes `redir_addr` in the next cycle, even if `fetch_step` is high. Otherwise `fetch_step`=1 adds 4 to `fetch_pc`, and `fetch_step`=0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dec_req | input | 1 | Decode-side request |
| dec_is_branch | input | 1 | Instruction is a conditional branch |
| dec_is_jump | input | 1 | Instruction is an unconditional jump |
| dec_on_zero | input | 1 | Branch sense: 1 redirects on zero, 0 on non-zero |
| dec_pc | input | AW | Address of the instruction |
| dec_target | input | AW | Branch or jump target |
| dec_ack | output | 1 | Decode-side acknowledge |
| exe_req | input | 1 | Execute-side request |
| exe_zero | input | 1 | Zero flag from execute |
| exe_ack | output | 1 | Execute-side acknowledge |
| redir_req | output | 1 | Request to fetch |
| redir_valid | output | 1 | Fetch must redirect |
| redir_addr | output | AW | Redirect target, or sequential address when not redirecting |
| redir_ack | input | 1 | Fetch acknowledge |
| fetch_step | input | 1 | Fetch advances sequentially |
| fetch_pc | output | AW | Fetch program counter |

## Verification
Assertions check these on every cycle:
- each acknowledge falls once its request has been seen low;
- an acknowledge rises only after its request;
- the fetch request and its payload stay stable until acknowledged;
- a new fetch request never rises under a high acknowledge;
- the program counter loads an accepted target or steps by 4.

Some behaviours can only be shown by the bench's scenarios:
- the redirect decision for every mix of branch, jump, sense and zero flag;
- both arrival orders, where no request may go out on one half alone;
- a decode request withheld while a redirect is outstanding.

// File: rtl/next_pc_resolver.sv
module next_pc_resolver #(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_req,
  input  logic          dec_is_branch,
  input  logic          dec_is_jump,
  input  logic          dec_on_zero,
  input  logic [AW-1:0] dec_pc,
  input  logic [AW-1:0] dec_target,
  output logic          dec_ack,
  input  logic          exe_req,
  input  logic          exe_zero,
  output logic          exe_ack,
  output logic          redir_req,
  output logic          redir_valid,
  output logic [AW-1:0] redir_addr,
  input  logic          redir_ack,
  input  logic          fetch_step,
  output logic [AW-1:0] fetch_pc
);
  localparam logic [AW-1:0] STEP = AW'(4);

  logic          addr_ready, zero_ready;
  logic          br_q, jmp_q, onz_q, zero_q;
  logic [AW-1:0] pc_q, tgt_q;

  wire dec_take = dec_req && !dec_ack && !addr_ready;
  wire exe_take = exe_req && !exe_ack && !zero_ready;
  wire sent     = redir_req && redir_ack;
  wire launch   = addr_ready && zero_ready && !redir_req && !redir_ack;
  wire go       = jmp_q || (br_q && (zero_q == onz_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_ack    <= 1'b0;
      addr_ready <= 1'b0;
      br_q       <= 1'b0;
      jmp_q      <= 1'b0;
      onz_q      <= 1'b0;
      pc_q       <= '0;
      tgt_q      <= '0;
    end else begin
      if (sent) addr_ready <= 1'b0;
      if (dec_take) begin
        addr_ready <= 1'b1;
        dec_ack    <= 1'b1;
        br_q       <= dec_is_branch;
        jmp_q      <= dec_is_jump;
        onz_q      <= dec_on_zero;
        pc_q       <= dec_pc;
        tgt_q      <= dec_target;
      end else if (!dec_req) begin
        dec_ack <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exe_ack    <= 1'b0;
      zero_ready <= 1'b0;
      zero_q     <= 1'b0;
    end else begin
      if (sent) zero_ready <= 1'b0;
      if (exe_take) begin
        zero_ready <= 1'b1;
        exe_ack    <= 1'b1;
        zero_q     <= exe_zero;
      end else if (!exe_req) begin
        exe_ack <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_req   <= 1'b0;
      redir_valid <= 1'b0;
      redir_addr  <= '0;
    end else if (sent) begin
      redir_req <= 1'b0;
    end else if (launch) begin
      redir_req   <= 1'b1;
      redir_valid <= go;
      redir_addr  <= go ? tgt_q : pc_q + STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   fetch_pc <= RESET_PC;
    else if (sent && redir_valid) fetch_pc <= redir_addr;
    else if (fetch_step)          fetch_pc <= fetch_pc + STEP;
  end
endmodule

// File: rtl/next_pc_resolver_checks.sv
module next_pc_resolver_checks #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dec_req,
  input logic          dec_ack,
  input logic          exe_req,
  input logic          exe_ack,
  input logic          redir_req,
  input logic          redir_valid,
  input logic [AW-1:0] redir_addr,
  input logic          redir_ack,
  input logic          fetch_step,
  input logic [AW-1:0] fetch_pc
);
  p_dec_ack_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_req |=> !dec_ack);
  p_dec_ack_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_ack) |-> $past(dec_req));
  p_exe_ack_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !exe_req |=> !exe_ack);
  p_exe_ack_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exe_ack) |-> $past(exe_req));
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redir_req && !redir_ack |=> redir_req && $stable(redir_valid) && $stable(redir_addr));
  p_req_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redir_req && redir_ack |=> !redir_req);
  p_req_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redir_req) |-> !$past(redir_ack));
  p_pc_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    redir_req && redir_ack && redir_valid |=> fetch_pc == $past(redir_addr));
  p_pc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(redir_req && redir_ack && redir_valid) && fetch_step
      |=> fetch_pc == $past(fetch_pc) + AW'(4));
  p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(redir_req && redir_ack && redir_valid) && !fetch_step |=> $stable(fetch_pc));
endmodule

bind next_pc_resolver next_pc_resolver_checks #(.AW(AW)) u_checks (
  .clk(clk), .rst_n(rst_n), .dec_req(dec_req), .dec_ack(dec_ack),
  .exe_req(exe_req), .exe_ack(exe_ack), .redir_req(redir_req),
  .redir_valid(redir_valid), .redir_addr(redir_addr), .redir_ack(redir_ack),
  .fetch_step(fetch_step), .fetch_pc(fetch_pc)
);

// File: tb/test_next_pc_resolver.sv
module test_next_pc_resolver;
  localparam int AW = 32;
  localparam logic [AW-1:0] RPC = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_req = 0, dec_is_branch = 0, dec_is_jump = 0, dec_on_zero = 0;
  logic [AW-1:0] dec_pc = '0, dec_target = '0;
  logic dec_ack, exe_req = 0, exe_zero = 0, exe_ack;
  logic redir_req, redir_valid, redir_ack = 0, fetch_step = 0;
  logic [AW-1:0] redir_addr, fetch_pc;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;
  logic [AW-1:0] exp_pc;

  always #4 clk = ~clk;

  next_pc_resolver #(.AW(AW), .RESET_PC(RPC)) i_next_pc_resolver (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_dec(input bit br, input bit jmp, input bit onz, input logic [AW-1:0] pc, input logic [AW-1:0] tgt);
    @(negedge clk);
    dec_req = 1; dec_is_branch = br; dec_is_jump = jmp; dec_on_zero = onz;
    dec_pc = pc; dec_target = tgt;
    @(negedge clk);
    chk(dec_ack == 1, "R2 ack rise", dec_ack, 1);
    dec_req = 0;
    @(negedge clk);
    chk(dec_ack == 0, "R2 ack fall", dec_ack, 0);
  endtask

  task automatic send_exe(input bit z);
    @(negedge clk);
    exe_req = 1; exe_zero = z;
    @(negedge clk);
    chk(exe_ack == 1, "R4 ack rise", exe_ack, 1);
    exe_req = 0;
    @(negedge clk);
    chk(exe_ack == 0, "R4 ack fall", exe_ack, 0);
  endtask

  task automatic finish_redir(input bit ev, input logic [AW-1:0] ea, input bit step, input string tag);
    while (!redir_req) @(negedge clk);
    chk(redir_valid == ev, tag, redir_valid, ev);
    chk(redir_addr == ea, ev ? tag : "R8", redir_addr, ea);
    repeat (2) @(negedge clk);
    chk(redir_req && redir_valid == ev && redir_addr == ea, "R9 hold", redir_addr, ea);
    redir_ack = 1; fetch_step = step;
    @(negedge clk);
    if (ev) exp_pc = ea; else if (step) exp_pc = exp_pc + 4;
    chk(redir_req == 0, "R9 release", redir_req, 0);
    chk(fetch_pc == exp_pc, "R10", fetch_pc, exp_pc);
    redir_ack = 0; fetch_step = 0;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dec_ack == 0 && exe_ack == 0 && redir_req == 0, "R1 outputs", {dec_ack, exe_ack, redir_req}, 0);
    chk(fetch_pc == RPC, "R1 pc", fetch_pc, RPC);
    rst_n = 1;
    @(negedge clk);
    chk(fetch_pc == RPC && redir_req == 0, "R1 after", fetch_pc, RPC);
    exp_pc = RPC;

    for (int k = 0; k < 3; k++) begin
      fetch_step = (k != 1);
      @(negedge clk);
      if (k != 1) exp_pc = exp_pc + 4;
      chk(fetch_pc == exp_pc, "R10 step", fetch_pc, exp_pc);
    end
    fetch_step = 0;

    for (int i = 0; i < 32; i++) begin
      bit br, jmp, onz, z, exe_first, ev;
      logic [AW-1:0] pc, tgt, ea;
      br = i[0]; jmp = i[1]; onz = i[2]; z = i[3]; exe_first = i[4];
      pc = 32'h1000 + 32'(i) * 16;
      tgt = 32'h8000_0000 ^ (32'(i) << 8);
      ev = jmp || (br && (z == onz));
      ea = ev ? tgt : pc + 4;
      if (exe_first) send_exe(z); else send_dec(br, jmp, onz, pc, tgt);
      repeat (3) @(negedge clk);
      chk(redir_req == 0, "R5 one half", redir_req, 0);
      if (exe_first) send_dec(br, jmp, onz, pc, tgt); else send_exe(z);
      finish_redir(ev, ea, i[1] ^ i[3], jmp ? "R6" : (br ? "R7" : "R8"));
    end

    send_dec(0, 0, 0, 32'h2000, 32'h3000);
    @(negedge clk);
    dec_req = 1; dec_is_jump = 1; dec_pc = 32'h4000; dec_target = 32'h5000;
    repeat (4) @(negedge clk);
    chk(dec_ack == 0, "R3 withheld", dec_ack, 0);
    send_exe(1);
    finish_redir(0, 32'h2004, 1, "R3 first");
    while (!dec_ack) @(negedge clk);
    dec_req = 0;
    dec_is_jump = 0;
    send_exe(0);
    finish_redir(1, 32'h5000, 0, "R3 second");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule